// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

This block is a countdown watchdog with two stages of expiry. A prescaler divides an external tick pulse by 64, and each divided tick decrements a counter that is loaded with a programmed timeout. The first expiry sets a sticky status flag, which can raise an interrupt, and arms a second stage. If the counter expires again before software reloads it, the block issues a one-cycle system reset request. A no-reboot bit can block that request, and a hardware strap input can hold the no-reboot bit set.

Software uses a byte-wide register port with a write strobe and a combinational read. The control byte is at address 0: bit 0 is halt, bit 1 is the sticky status (write 1 to clear), and bit 2 is the read-only second-stage flag. The timer byte is at address 1: the low 6 bits hold the timeout field and bits 7:6 are spare storage. Any write to address 2 is a reload. Address 3 holds the interrupt enables: bit 0 is the source enable and bit 1 is the global enable. Address 4 holds the no-reboot bit in bit 0. Any other address reads as zero.

Top module: `wdog_dual_expiry`

## Requirements
- R1: After reset the control byte reads 0x01 (halted), the timer byte reads 0x3C (field 60, spare bits 0), the enables read 0x00, the no-reboot byte reads 0x01, and both outputs are low.
- R2: A timer-byte write with a legal field stores the field. Bits 7:6 always take the written value, whether or not the field is legal.
- R3: While halt is set the countdown does not move. After halt is cleared it resumes from the held count and prescaler phase.
- R4: A field value below 2 or above 60 is rejected, and the previous field is kept.
- R5: A write of any data to address 2 restarts the count from the programmed field. The first expiry then lands exactly 64·T pulses of tick_in later.
- R6: Every expiry sets control bit 1 and control bit 2. Writing 1 to control bit 1 clears it, and writing 0 to it has no effect on it.
- R7: wdt_irq is high exactly when the status bit and both enable bits are set.
- R8: When an expiry happens while control bit 2 is already set, sys_reset_req goes high for exactly one cycle. For a timeout of T this is 128·T pulses after a reload.
- R9: A reload clears control bit 2, so the next expiry after a reload does not request a reset.
- R10: While the no-reboot bit is set, no reset is requested. While strap_noreboot is high, the bit is forced to 1 and stays 1 after the strap drops, until it is written to 0.
- R11: Reloads spaced closer than the timeout keep both wdt_irq and sys_reset_req low and leave bits 1 and 2 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Prescaler input pulse, one per time base step |
| strap_noreboot | input | 1 | Hardware strap that holds the no-reboot bit set |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| wdt_irq | output | 1 | Timeout interrupt request (level) |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
A wrong prescaler phase or a wrong count shows as a status bit that rises one or more cycles off its computed edge. Every expiry is timed to the exact cycle after each reload or resume, so such an error is seen at the first expiry, within 64·T cycles. A stuck or wrongly cleared second-stage flag shows either as a reset request in a cycle where none is due, or as a missing pulse at 128·T cycles. The control byte exposes the flag directly after each step. A lost strap force or a field that should have been rejected appears on the next read of the configuration or timer byte.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic [2:0] {
      A_CTRL  = 3'd0,
      A_TIMER = 3'd1,
      A_KICK  = 3'd2,
      A_IEN   = 3'd3,
      A_CFG   = 3'd4
   } wdog_addr_e;

   localparam int CTRL_HALT = 0;
   localparam int CTRL_STS  = 1;
   localparam int CTRL_ARM  = 2;
   localparam int IEN_SRC   = 0;
   localparam int IEN_GLB   = 1;
endpackage

// File: rtl/wdog_presc.sv
module wdog_presc #(
   parameter int PRESC_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_in,
   input  logic run,
   input  logic clear,
   output logic tick_out
);
   generate
      if (PRESC_W == 0) begin : g_direct
         assign tick_out = pulse_in & run & ~clear;
      end else begin : g_div
         logic [PRESC_W-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= '0;
            else if (clear)
               phase_q <= '0;
            else if (run && pulse_in)
               phase_q <= phase_q + 1'b1;
         end
         assign tick_out = pulse_in & run & ~clear & (phase_q == '1);
      end
   endgenerate
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int TO_W    = 6,
   parameter int RST_CNT = 60
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            reload,
   input  logic [TO_W-1:0] timeout,
   output logic [TO_W-1:0] cnt,
   output logic            expire
);
   localparam logic [TO_W-1:0] ONE = TO_W'(1);

   assign expire = tick & ~reload & (cnt <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= TO_W'(RST_CNT);
      else if (reload || expire)
         cnt <= timeout;
      else if (tick)
         cnt <= cnt - ONE;
   end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int TO_W   = 6,
   parameter int TO_MIN = 2,
   parameter int TO_MAX = 60
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [2:0]      addr,
   input  logic [7:0]      wdata,
   input  logic            strap,
   input  logic            expire,
   output logic [7:0]      rdata,
   output logic            kick,
   output logic            halt,
   output logic [TO_W-1:0] field,
   output logic            armed,
   output logic            nrb_q,
   output logic            irq,
   output logic            rst_req
);
   localparam int SPARE_W = 8 - TO_W;

   logic sts_q, en_src_q, en_glb_q;
   logic wr_ctrl, wr_timer, wr_ien, wr_cfg, field_ok;
   logic [7:0] timer_rd;
   logic [TO_W-1:0] new_field;

   assign wr_ctrl   = wr && (addr == A_CTRL);
   assign wr_timer  = wr && (addr == A_TIMER);
   assign kick      = wr && (addr == A_KICK);
   assign wr_ien    = wr && (addr == A_IEN);
   assign wr_cfg    = wr && (addr == A_CFG);
   assign new_field = wdata[TO_W-1:0];
   assign field_ok  = (new_field >= TO_W'(TO_MIN)) && (new_field <= TO_W'(TO_MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt     <= 1'b1;
         sts_q    <= 1'b0;
         armed    <= 1'b0;
         field    <= TO_W'(TO_MAX);
         en_src_q <= 1'b0;
         en_glb_q <= 1'b0;
         nrb_q    <= 1'b1;
         rst_req  <= 1'b0;
      end else begin
         rst_req <= expire & armed & ~(nrb_q | strap);
         if (wr_ctrl)
            halt <= wdata[CTRL_HALT];
         if (expire)
            sts_q <= 1'b1;
         else if (wr_ctrl && wdata[CTRL_STS])
            sts_q <= 1'b0;
         if (kick)
            armed <= 1'b0;
         else if (expire)
            armed <= 1'b1;
         if (wr_timer && field_ok)
            field <= new_field;
         if (wr_ien) begin
            en_src_q <= wdata[IEN_SRC];
            en_glb_q <= wdata[IEN_GLB];
         end
         nrb_q <= (wr_cfg ? wdata[0] : nrb_q) | strap;
      end
   end

   generate
      if (SPARE_W > 0) begin : g_spare
         logic [SPARE_W-1:0] spare_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               spare_q <= '0;
            else if (wr_timer)
               spare_q <= wdata[7:TO_W];
         end
         assign timer_rd = {spare_q, field};
      end else begin : g_nospare
         assign timer_rd = field;
      end
   endgenerate

   assign irq = sts_q & en_src_q & en_glb_q;

   always_comb begin
      rdata = 8'h00;
      case (addr)
         A_CTRL:  rdata = {5'b0, armed, sts_q, halt};
         A_TIMER: rdata = timer_rd;
         A_IEN:   rdata = {6'b0, en_glb_q, en_src_q};
         A_CFG:   rdata = {7'b0, nrb_q | strap};
         default: rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/wdog_dual_expiry.sv
module wdog_dual_expiry #(
   parameter int TO_W    = 6,
   parameter int TO_MIN  = 2,
   parameter int TO_MAX  = 60,
   parameter int PRESC_W = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_in,
   input  logic       strap_noreboot,
   input  logic       bus_wr,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       wdt_irq,
   output logic       sys_reset_req
);
   generate
      if (TO_W < 2 || TO_W > 8) begin : g_bad_w
         $error("TO_W must be within 2..8");
      end
      if (TO_MIN < 1 || TO_MIN > TO_MAX || TO_MAX > (2**TO_W) - 1) begin : g_bad_range
         $error("timeout limits do not fit the field");
      end
      if (PRESC_W < 0 || PRESC_W > 16) begin : g_bad_presc
         $error("PRESC_W must be within 0..16");
      end
   endgenerate

   logic            kick, halt, armed, nrb_q, tick, expire;
   logic [TO_W-1:0] field, cnt;

   wdog_regs #(.TO_W(TO_W), .TO_MIN(TO_MIN), .TO_MAX(TO_MAX)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .strap(strap_noreboot), .expire(expire), .rdata(bus_rdata), .kick(kick),
      .halt(halt), .field(field), .armed(armed), .nrb_q(nrb_q),
      .irq(wdt_irq), .rst_req(sys_reset_req)
   );

   wdog_presc #(.PRESC_W(PRESC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .pulse_in(tick_in), .run(~halt),
      .clear(kick), .tick_out(tick)
   );

   wdog_count #(.TO_W(TO_W), .RST_CNT(TO_MAX)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reload(kick),
      .timeout(field), .cnt(cnt), .expire(expire)
   );
endmodule

// File: rtl/wdog_dual_expiry_chk.sv
module wdog_dual_expiry_chk #(
   parameter int TO_W   = 6,
   parameter int TO_MIN = 2,
   parameter int TO_MAX = 60
) (
   input logic            clk,
   input logic            rst_n,
   input logic            kick,
   input logic            halt,
   input logic [TO_W-1:0] cnt,
   input logic [TO_W-1:0] field,
   input logic            armed,
   input logic            nrb_q,
   input logic            strap_noreboot,
   input logic            sys_reset_req
);
   p_halt_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !kick) |=> $stable(cnt));

   p_field_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (field >= TO_W'(TO_MIN)) && (field <= TO_W'(TO_MAX)));

   p_reset_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |=> !sys_reset_req);

   p_reset_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |-> armed);

   p_noreboot_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |-> (!$past(nrb_q) && !$past(strap_noreboot)));

   p_strap_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(strap_noreboot) |-> nrb_q);
endmodule

bind wdog_dual_expiry wdog_dual_expiry_chk #(.TO_W(TO_W), .TO_MIN(TO_MIN), .TO_MAX(TO_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .kick(kick), .halt(halt), .cnt(cnt), .field(field),
   .armed(armed), .nrb_q(nrb_q), .strap_noreboot(strap_noreboot),
   .sys_reset_req(sys_reset_req)
);

// File: tb/tb_wdog_dual_expiry.sv
`timescale 1ns/1ps
module tb_wdog_dual_expiry;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_in = 1'b1;
   logic       strap_noreboot = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       wdt_irq, sys_reset_req;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam int PULSES = 64;
   localparam int FMIN = 2;
   localparam int FMAX = 60;

   always #2 clk = ~clk;

   wdog_dual_expiry dut (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .strap_noreboot(strap_noreboot),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .sys_reset_req(sys_reset_req)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [2:0] a, input int exp);
      bus_addr = a;
      #0.5;
      check(tag, int'(bus_rdata), exp);
   endtask

   task automatic run_count(input int n, output int first, output int nrst, output int nirq);
      first = -1; nrst = 0; nirq = 0;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (sys_reset_req) begin
            nrst++;
            if (first < 0) first = i;
         end
         if (wdt_irq) nirq++;
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int first, nrst, nirq, prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_check("R1 ctrl", 3'd0, 8'h01);
      rd_check("R1 timer", 3'd1, 8'h3C);
      rd_check("R1 ien", 3'd3, 8'h00);
      rd_check("R1 cfg", 3'd4, 8'h01);
      check("R1 irq", int'(wdt_irq), 0);
      check("R1 rst", int'(sys_reset_req), 0);

      // R2 / R4 sweep over every field value
      prev = FMAX;
      for (int v = 0; v < 64; v++) begin
         logic [7:0] d;
         int expf;
         d = {v[1:0], v[5:0]};
         expf = (v >= FMIN && v <= FMAX) ? v : prev;
         wr(3'd1, d);
         rd_check((v >= FMIN && v <= FMAX) ? "R2 legal field" : "R4 illegal field",
                  3'd1, {v[1:0], 6'(expf)});
         prev = expf;
      end

      // setup: T = 2, enables on, no-reboot off
      wr(3'd4, 8'h00);
      rd_check("R10 cfg clear", 3'd4, 0);
      wr(3'd1, 8'h02);
      wr(3'd3, 8'h03);

      // R3 halted: nothing happens
      wr(3'd2, 8'h5A);
      run_count(400, first, nrst, nirq);
      rd_check("R3 halted no expiry", 3'd0, 8'h01);
      check("R3 halted irq", nirq, 0);

      // R5 exact first expiry, T=2
      wr(3'd0, 8'h00);
      wr(3'd2, 8'hA5);
      repeat (PULSES * 2 - 1) @(negedge clk);
      rd_check("R5 before expiry", 3'd0, 8'h00);
      check("R7 irq before", int'(wdt_irq), 0);
      @(negedge clk);
      rd_check("R6 after expiry", 3'd0, 8'h06);
      check("R7 irq after", int'(wdt_irq), 1);
      check("R8 no reset on first", int'(sys_reset_req), 0);

      // R7 gating over all enable combinations
      wr(3'd0, 8'h01);
      for (int k = 0; k < 4; k++) begin
         wr(3'd3, 8'(k));
         #0.5;
         check("R7 irq gating", int'(wdt_irq), (k == 3) ? 1 : 0);
      end
      rd_check("R6 status sticky", 3'd0, 8'h07);

      // R6 write-1-clear
      wr(3'd0, 8'h03);
      rd_check("R6 w1c", 3'd0, 8'h05);
      check("R6 irq cleared", int'(wdt_irq), 0);

      // R9 reload clears second-stage flag
      wr(3'd2, 8'h00);
      rd_check("R9 reload clears arm", 3'd0, 8'h01);

      // R3 resume from held phase
      wr(3'd0, 8'h00);
      wr(3'd2, 8'h11);
      repeat (60) @(negedge clk);
      wr(3'd0, 8'h01);
      repeat (500) @(negedge clk);
      rd_check("R3 frozen", 3'd0, 8'h01);
      wr(3'd0, 8'h00);
      repeat (PULSES * 2 - 61 - 1) @(negedge clk);
      rd_check("R3 resume before", 3'd0, 8'h00);
      @(negedge clk);
      rd_check("R3 resume expiry", 3'd0, 8'h06);

      // R8 second expiry reset pulse at 128*T
      wr(3'd0, 8'h03);
      wr(3'd0, 8'h02);
      wr(3'd2, 8'h00);
      run_count(300, first, nrst, nirq);
      check("R8 reset cycle", first, PULSES * 2 * 2);
      check("R8 single pulse", nrst, 1);
      wr(3'd0, 8'h03);

      // R9 reload between expiries prevents reset
      wr(3'd0, 8'h02);
      wr(3'd2, 8'h00);
      run_count(PULSES * 2 + 4, first, nrst, nirq);
      wr(3'd2, 8'h00);
      run_count(PULSES * 2 + 4, first, nrst, nirq);
      check("R9 no reset after reload", nrst, 0);
      rd_check("R9 arm after one expiry", 3'd0, 8'h06);

      // R10 no-reboot blocks the reset
      wr(3'd0, 8'h03);
      wr(3'd4, 8'h01);
      wr(3'd0, 8'h02);
      wr(3'd2, 8'h00);
      run_count(300, first, nrst, nirq);
      check("R10 no-reboot blocks", nrst, 0);
      rd_check("R10 armed anyway", 3'd0, 8'h06);

      // R10 strap forcing
      wr(3'd0, 8'h03);
      strap_noreboot = 1'b1;
      wr(3'd4, 8'h00);
      rd_check("R10 strap forces", 3'd4, 1);
      wr(3'd0, 8'h02);
      wr(3'd2, 8'h00);
      run_count(300, first, nrst, nirq);
      check("R10 strap blocks reset", nrst, 0);
      wr(3'd0, 8'h03);
      strap_noreboot = 1'b0;
      @(negedge clk);
      rd_check("R10 stays set after strap", 3'd4, 1);
      wr(3'd4, 8'h00);
      rd_check("R10 clear after strap", 3'd4, 0);

      // R11 periodic reload
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h02);
      begin
         int tr, ti;
         tr = 0; ti = 0;
         for (int j = 0; j < 20; j++) begin
            run_count(120, first, nrst, nirq);
            tr += nrst; ti += nirq;
            wr(3'd2, 8'(j * 13));
         end
         check("R11 no reset", tr, 0);
         check("R11 no irq", ti, 0);
      end
      rd_check("R11 flags clear", 3'd0, 8'h00);

      // R5 T=3 with arbitrary reload data
      wr(3'd0, 8'h01);
      wr(3'd1, 8'h03);
      wr(3'd0, 8'h00);
      wr(3'd2, 8'hFF);
      repeat (PULSES * 3 - 1) @(negedge clk);
      rd_check("R5 T3 before", 3'd0, 8'h00);
      @(negedge clk);
      rd_check("R5 T3 expiry", 3'd0, 8'h06);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule